// File: doc/BRIEF.md
# Effective Address Sequencer

This block resolves the operand location for one instruction of an 8-bit processor with a 16-bit address space. A request carries an addressing mode, the program counter (pointing at the first operand byte, after the opcode), the two index registers and the accumulator. The sequencer then walks through the byte reads the mode needs on a plain synchronous read port, one read per cycle. It returns the final effective address, the operand byte found there, the program counter advanced past the operand bytes, and a flag that tells the execution stage to add one cycle because an indexed access crossed a page.

Zero-page arithmetic stays inside page zero, and the jump-through-pointer mode keeps the historical flaw where the second pointer byte never leaves the pointer's page. Relative mode yields the branch target and the raw offset. Instruction execution and memory writes belong to other blocks.

Top module: `addr_gen_seq`

## Requirements
- R1: Mode codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 pointer-in-zero-page after adding X, 10 zero-page pointer then +Y, 11 jump through pointer, 12 relative. Implied and accumulator (and codes 13 to 15) make no read, return the accumulator as operand, effective address 0, the unchanged program counter, and raise done on the first edge after the request.
- R2: Reads go out one per cycle with `mem_rd` high; `mem_rdata` carries the addressed byte one cycle after the strobe. A 16-bit value takes its low byte from the lower address and its high byte from the next one.
- R3: Immediate mode returns the program counter as the effective address and the byte there as operand.
- R4: Zero page modes form the address from the operand byte; the indexed ones add X or Y modulo 256, so the address high byte is always 0.
- R5: Absolute modes take a two-byte address; indexed forms add X or Y over the full 16 bits and raise `page_cross` when the low-byte addition carries. No other mode raises `page_cross`.
- R6: Mode 9 adds X to the zero-page byte modulo 256 and reads the pointer's low byte there and its high byte at the next location, also wrapped inside page zero.
- R7: Mode 10 reads a 16-bit pointer from zero page (second byte wrapped in page zero) and adds Y to the whole pointer.
- R8: Mode 11 reads the pointer's high byte from the same page with only the low byte incremented; a pointer at xxFF takes its high byte from xx00.
- R9: Relative mode returns the offset byte as operand and, as effective address, the advanced program counter plus the offset sign-extended from bit 7.
- R10: The returned program counter is the input plus 2 for modes 6, 7, 8 and 11, plus 1 for the other memory modes.
- R11: A memory mode needs 2 (immediate, relative), 3 (zero page), 4 (absolute), 5 (indirect with index) or 6 (jump through pointer) edges after the request until done; `busy` is high in between, `done` lasts one cycle, and a request arriving while busy is ignored. All non-final steps read; the operand is read at the effective address.
- R12: After reset `busy`, `done`, `mem_rd` and `page_cross` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 4 | Addressing mode code |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index |
| y_in | input | 8 | Y index |
| acc_in | input | 8 | Accumulator value |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 16 | Effective address |
| operand | output | 8 | Operand byte |
| pc_out | output | 16 | Advanced program counter |
| page_cross | output | 1 | Extra cycle for indexed page crossing |

## Verification
The case where two things meet in one cycle is a fresh request that lands while an earlier request is still reading memory. The bench raises an implied-mode request with a different accumulator during the first read of an absolute access; it then expects the absolute result, latency and read count unchanged, and no extra done pulse. Every other mode is compared cycle by cycle against a behavioural model that recomputes the address from a scripted memory.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPL = 4'd0,
    AM_ACCU = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_ABS  = 4'd6,
    AM_ABSX = 4'd7,
    AM_ABSY = 4'd8,
    AM_INDX = 4'd9,
    AM_INDY = 4'd10,
    AM_JIND = 4'd11,
    AM_REL  = 4'd12
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP1,
    ST_OP2,
    ST_PLO,
    ST_PHI,
    ST_DATA,
    ST_FIN
  } step_e;

  function automatic logic uses_memory(input logic [MODE_W-1:0] m);
    return (m >= 4'(AM_IMM)) && (m <= 4'(AM_REL));
  endfunction
endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BYTE_W-1:0] idx,
  input  logic              wrap,
  output logic [ADDR_W-1:0] sum,
  output logic              carry
);
  logic [BYTE_W:0]   lo_ext;
  logic [BYTE_W-1:0] hi;

  always_comb begin
    lo_ext = {1'b0, base[BYTE_W-1:0]} + {1'b0, idx};
    carry  = lo_ext[BYTE_W];
    if (wrap) hi = base[ADDR_W-1:BYTE_W];
    else      hi = base[ADDR_W-1:BYTE_W] + {{(BYTE_W-1){1'b0}}, lo_ext[BYTE_W]};
    sum = {hi, lo_ext[BYTE_W-1:0]};
  end
endmodule

// File: rtl/eag_step_next.sv
module eag_step_next
  import eag_pkg::*;
(
  input  step_e  st,
  input  amode_e md,
  input  logic   go,
  output step_e  nxt
);
  always_comb begin
    nxt = ST_IDLE;
    unique case (st)
      ST_IDLE: nxt = (go && uses_memory(md)) ? ST_OP1 : ST_IDLE;
      ST_OP1: begin
        if (md == AM_IMM || md == AM_REL)                    nxt = ST_FIN;
        else if (md == AM_ZP || md == AM_ZPX || md == AM_ZPY) nxt = ST_DATA;
        else if (md == AM_INDX || md == AM_INDY)             nxt = ST_PLO;
        else                                                 nxt = ST_OP2;
      end
      ST_OP2:  nxt = (md == AM_JIND) ? ST_PLO : ST_DATA;
      ST_PLO:  nxt = ST_PHI;
      ST_PHI:  nxt = ST_DATA;
      ST_DATA: nxt = ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/addr_gen_seq.sv
module addr_gen_seq
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] y_in,
  input  logic [BYTE_W-1:0] acc_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [BYTE_W-1:0] operand,
  output logic [ADDR_W-1:0] pc_out,
  output logic              page_cross
);
  step_e             state, state_nxt;
  amode_e            mode_r;
  logic [ADDR_W-1:0] pc_r, ptr_q, ea_q;
  logic [BYTE_W-1:0] x_r, y_r, lo_q;
  logic              cross_q;

  logic              in_zp, in_absidx, two_byte;
  logic [ADDR_W-1:0] dat_base, ptr_base, dat_sum, ptr_sum, ptr_next, rel_tgt;
  logic [BYTE_W-1:0] dat_idx, ptr_idx;
  logic              dat_carry, ptr_carry;

  eag_step_next u_step (
    .st  (state),
    .md  ((state == ST_IDLE) ? amode_e'(mode) : mode_r),
    .go  (start),
    .nxt (state_nxt)
  );

  always_comb begin
    in_zp     = (mode_r == AM_ZP) || (mode_r == AM_ZPX) || (mode_r == AM_ZPY);
    in_absidx = (mode_r == AM_ABSX) || (mode_r == AM_ABSY);
    two_byte  = (mode_r == AM_ABS) || in_absidx || (mode_r == AM_JIND);
    dat_base  = in_zp ? {{BYTE_W{1'b0}}, mem_rdata} : {mem_rdata, lo_q};
    if (mode_r == AM_ZPX || mode_r == AM_ABSX)                              dat_idx = x_r;
    else if (mode_r == AM_ZPY || mode_r == AM_ABSY || mode_r == AM_INDY)   dat_idx = y_r;
    else                                                                   dat_idx = '0;
    ptr_base  = (mode_r == AM_JIND) ? {mem_rdata, lo_q} : {{BYTE_W{1'b0}}, mem_rdata};
    ptr_idx   = (mode_r == AM_INDX) ? x_r : '0;
    ptr_next  = {ptr_q[ADDR_W-1:BYTE_W], ptr_q[BYTE_W-1:0] + BYTE_W'(1)};
    rel_tgt   = pc_r + ADDR_W'(1) + {{BYTE_W{mem_rdata[BYTE_W-1]}}, mem_rdata};
  end

  eag_index_add #(.BYTE_W(BYTE_W)) u_dat_add (
    .base (dat_base), .idx (dat_idx), .wrap (in_zp), .sum (dat_sum), .carry (dat_carry)
  );

  eag_index_add #(.BYTE_W(BYTE_W)) u_ptr_add (
    .base (ptr_base), .idx (ptr_idx), .wrap (1'b1), .sum (ptr_sum), .carry (ptr_carry)
  );

  always_comb begin
    mem_addr = '0;
    mem_rd   = 1'b1;
    unique case (state)
      ST_OP1:  mem_addr = pc_r;
      ST_OP2:  mem_addr = pc_r + ADDR_W'(1);
      ST_PLO:  mem_addr = ptr_sum;
      ST_PHI:  mem_addr = ptr_next;
      ST_DATA: mem_addr = dat_sum;
      default: mem_rd   = 1'b0;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mode_r     <= AM_IMPL;
      pc_r       <= '0;
      x_r        <= '0;
      y_r        <= '0;
      lo_q       <= '0;
      ptr_q      <= '0;
      ea_q       <= '0;
      cross_q    <= 1'b0;
      done       <= 1'b0;
      eff_addr   <= '0;
      operand    <= '0;
      pc_out     <= '0;
      page_cross <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_r  <= amode_e'(mode);
          pc_r    <= pc_in;
          x_r     <= x_in;
          y_r     <= y_in;
          cross_q <= 1'b0;
          if (!uses_memory(mode)) begin
            done       <= 1'b1;
            eff_addr   <= '0;
            operand    <= acc_in;
            pc_out     <= pc_in;
            page_cross <= 1'b0;
          end
        end
        ST_OP2:  lo_q  <= mem_rdata;
        ST_PLO:  ptr_q <= ptr_sum;
        ST_PHI:  lo_q  <= mem_rdata;
        ST_DATA: begin
          ea_q    <= dat_sum;
          cross_q <= dat_carry && in_absidx;
        end
        ST_FIN: begin
          done       <= 1'b1;
          operand    <= mem_rdata;
          page_cross <= cross_q;
          pc_out     <= pc_r + (two_byte ? ADDR_W'(2) : ADDR_W'(1));
          if (mode_r == AM_IMM)      eff_addr <= pc_r;
          else if (mode_r == AM_REL) eff_addr <= rel_tgt;
          else                       eff_addr <= ea_q;
        end
        default: ;
      endcase
    end
  end

  logic unused_carry;
  assign unused_carry = ptr_carry;
endmodule

// File: rtl/eag_checks.sv
module eag_checks
  import eag_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [MODE_W-1:0] mode,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [BYTE_W-1:0] operand,
  input logic [ADDR_W-1:0] pc_out,
  input logic              page_cross,
  input logic [MODE_W-1:0] mode_q
);
  a_r2_read_needs_busy: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  a_r11_done_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r1_no_read_fast_done: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !uses_memory(mode)) |=> (done && !busy && !mem_rd));

  a_r4_zp_page_zero: assert property (@(posedge clk) disable iff (rst)
    (done && (mode_q == 4'(AM_ZP) || mode_q == 4'(AM_ZPX) || mode_q == 4'(AM_ZPY)))
      |-> (eff_addr[ADDR_W-1:BYTE_W] == '0));

  a_r5_cross_only_indexed: assert property (@(posedge clk) disable iff (rst)
    (done && page_cross) |-> (mode_q == 4'(AM_ABSX) || mode_q == 4'(AM_ABSY)));

  a_r9_branch_target: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == 4'(AM_REL))
      |-> (eff_addr == pc_out + {{BYTE_W{operand[BYTE_W-1]}}, operand}));
endmodule

bind addr_gen_seq eag_checks #(.BYTE_W(BYTE_W)) u_eag_checks (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mode       (mode),
  .busy       (busy),
  .done       (done),
  .mem_rd     (mem_rd),
  .eff_addr   (eff_addr),
  .operand    (operand),
  .pc_out     (pc_out),
  .page_cross (page_cross),
  .mode_q     (mode_r)
);

// File: tb/addr_gen_seq_bench.sv
module addr_gen_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, y_in = '0, acc_in = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done, page_cross;
  logic [15:0] eff_addr, pc_out;
  logic [7:0]  operand;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  bit finished = 0;
  logic [7:0] ovr [int];

  always #5 clk = ~clk;

  addr_gen_seq u_addr_gen_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .acc_in(acc_in), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .eff_addr(eff_addr), .operand(operand), .pc_out(pc_out),
    .page_cross(page_cross)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mb(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input int md, input logic [15:0] pc,
                        input logic [7:0] xv, input logic [7:0] yv,
                        input logic [7:0] av, input bit poke);
    logic [7:0]  b1, b2, zp;
    logic [15:0] ea, pco, ptr;
    logic [7:0]  opv;
    logic        cr;
    int          lat, rd0;
    b1 = mb(pc); b2 = mb(pc + 16'd1);
    ea = '0; opv = av; pco = pc; cr = 1'b0; lat = 0;
    case (md)
      2:  begin ea = pc; lat = 2; end
      3:  begin ea = {8'h00, b1}; lat = 3; end
      4:  begin ea = {8'h00, 8'(b1 + xv)}; lat = 3; end
      5:  begin ea = {8'h00, 8'(b1 + yv)}; lat = 3; end
      6:  begin ea = {b2, b1}; lat = 4; end
      7:  begin ea = {b2, b1} + {8'h00, xv}; cr = (int'(b1) + int'(xv)) > 255; lat = 4; end
      8:  begin ea = {b2, b1} + {8'h00, yv}; cr = (int'(b1) + int'(yv)) > 255; lat = 4; end
      9:  begin zp = 8'(b1 + xv); ea = {mb({8'h00, 8'(zp + 8'd1)}), mb({8'h00, zp})}; lat = 5; end
      10: begin ea = {mb({8'h00, 8'(b1 + 8'd1)}), mb({8'h00, b1})} + {8'h00, yv}; lat = 5; end
      11: begin ptr = {b2, b1}; ea = {mb({b2, 8'(b1 + 8'd1)}), mb(ptr)}; lat = 6; end
      12: begin ea = pc + 16'd1 + {{8{b1[7]}}, b1}; lat = 2; end
      default: ;
    endcase
    if (lat > 0) begin
      pco = pc + ((md == 6 || md == 7 || md == 8 || md == 11) ? 16'd2 : 16'd1);
      opv = (md == 2 || md == 12) ? b1 : mb(ea);
    end
    @(negedge clk);
    mode = 4'(md); pc_in = pc; x_in = xv; y_in = yv; acc_in = av; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rd0 = rd_cnt;
    for (int k = 0; k <= lat + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 0) begin start = 1'b1; mode = 4'd0; acc_in = ~av; end
      if (poke && k == 1) start = 1'b0;
      cmp(req, "done", int'(done), int'(k == lat));
      cmp(req, "busy", int'(busy), int'(k < lat));
      if (k == lat) begin
        cmp(req, "eff_addr", int'(eff_addr), int'(ea));
        cmp(req, "operand", int'(operand), int'(opv));
        cmp("R10", "pc_out", int'(pc_out), int'(pco));
        cmp(req, "page_cross", int'(page_cross), int'(cr));
      end
    end
    cmp("R2", "read count", rd_cnt - rd0, (lat == 0) ? 0 : lat - 1);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp("R12", "busy", int'(busy), 0);
    cmp("R12", "done", int'(done), 0);
    cmp("R12", "mem_rd", int'(mem_rd), 0);
    cmp("R12", "page_cross", int'(page_cross), 0);

    run_op("R1", 0, 16'h1234, 8'h01, 8'h02, 8'h3C, 0);
    run_op("R1", 1, 16'h2222, 8'h01, 8'h02, 8'hA5, 0);
    run_op("R1", 14, 16'h3333, 8'h00, 8'h00, 8'h77, 0);
    run_op("R3", 2, 16'h0200, 8'h00, 8'h00, 8'h00, 0);

    ovr.delete(); ovr[16'h0300] = 8'h80;
    run_op("R4", 3, 16'h0300, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h0300] = 8'hF0;
    run_op("R4", 4, 16'h0300, 8'h20, 8'h00, 8'h00, 0);
    ovr[16'h0300] = 8'hFE;
    run_op("R4", 5, 16'h0300, 8'h00, 8'h07, 8'h00, 0);

    ovr.delete(); ovr[16'h0400] = 8'h34; ovr[16'h0401] = 8'h12;
    run_op("R2", 6, 16'h0400, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h0400] = 8'h10;
    run_op("R5", 7, 16'h0400, 8'h05, 8'h00, 8'h00, 0);
    ovr[16'h0400] = 8'hF0;
    run_op("R5", 7, 16'h0400, 8'h20, 8'h00, 8'h00, 0);
    ovr[16'h04FF] = 8'hC0; ovr[16'h0500] = 8'hFF;
    run_op("R5", 8, 16'h04FF, 8'h00, 8'h50, 8'h00, 0);

    ovr.delete(); ovr[16'h0600] = 8'hFE; ovr[16'h00FF] = 8'h78; ovr[16'h0000] = 8'h56;
    run_op("R6", 9, 16'h0600, 8'h01, 8'h00, 8'h00, 0);
    ovr[16'h0600] = 8'h10;
    run_op("R6", 9, 16'h0600, 8'h05, 8'h00, 8'h00, 0);

    ovr.delete(); ovr[16'h0700] = 8'h40; ovr[16'h0040] = 8'hF0; ovr[16'h0041] = 8'h12;
    run_op("R7", 10, 16'h0700, 8'h00, 8'h20, 8'h00, 0);
    ovr[16'h0700] = 8'hFF; ovr[16'h00FF] = 8'h00; ovr[16'h0000] = 8'h44;
    run_op("R7", 10, 16'h0700, 8'h00, 8'h03, 8'h00, 0);

    ovr.delete(); ovr[16'h0800] = 8'h80; ovr[16'h0801] = 8'h30;
    run_op("R8", 11, 16'h0800, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h0800] = 8'hFF; ovr[16'h30FF] = 8'h11; ovr[16'h3000] = 8'h22; ovr[16'h3100] = 8'h99;
    run_op("R8", 11, 16'h0800, 8'h00, 8'h00, 8'h00, 0);

    ovr.delete(); ovr[16'h1000] = 8'h10;
    run_op("R9", 12, 16'h1000, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h1000] = 8'hF0;
    run_op("R9", 12, 16'h1000, 8'h00, 8'h00, 8'h00, 0);

    ovr.delete(); ovr[16'h0900] = 8'hEE; ovr[16'h0901] = 8'h0A;
    run_op("R11", 6, 16'h0900, 8'h00, 8'h00, 8'h5C, 1);
    run_op("R11", 11, 16'h0900, 8'h00, 8'h00, 8'h00, 1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule